// File: doc/BRIEF.md
# Configuration Register Serial Slave

This block is a serial slave that gives an external host read and write access to a bank of thirty-two 8-bit configuration registers. The host frames each transaction with an active-low select line. It then clocks in one instruction byte and one to four data bytes. The instruction byte carries three things: whether the transfer is a read or a write, how many data bytes follow, and a 5-bit starting address. Between data bytes the address moves automatically to the neighbouring register.

Register 0 controls the link itself. One bit picks the bit order of every byte on the line. The other picks where read data leaves the block: on the shared data line (3-wire), or on a dedicated output line (4-wire), in which case the shared line stays an input. Tri-state pads are not modelled. Each line instead has an output value and an output-enable. The serial pins are resampled in the fast system clock, so the whole block runs on one clock with a synchronous active-high reset.

Top module: `spi_cfg_slave`

## Requirements
- R1: The instruction byte holds the direction in bit 7 (1 = read), the byte count in bits 6:5 (00 = one byte, 01 = two, 10 = three, 11 = four) and the start address in bits 4:0. The data bytes follow it with no gap.
- R2: Input bits are taken on rising serial-clock edges, and output bits change on falling edges. The first read bit is driven at the falling edge that follows the eighth instruction bit.
- R3: While the select line is high, both output-enables are low and serial-clock activity changes nothing. Raising select in the middle of a byte abandons the transfer, and the partial byte is not written.
- R4: With register 0 bit 7 clear (3-wire, the reset state), read data leaves on the shared line, and the dedicated output-enable is never asserted.
- R5: With register 0 bit 7 set (4-wire), read data leaves on the dedicated line, and the shared line's output-enable stays low for the whole read.
- R6: An output-enable is high only while read data bits are being shifted out. It is low during the instruction byte, during writes, and after the falling edge that ends the last read bit.
- R7: Register 0 bit 6 chooses the bit order: 0 = MSB first (reset), 1 = LSB first. The order applies to instruction and data bytes alike. Both link settings are captured when a transaction opens, so a change takes effect from the next one.
- R8: After each data byte the address decrements in MSB-first mode and increments in LSB-first mode, wrapping modulo 32.
- R9: Bits that a register does not define always read 0, whatever was written. The defined-bit masks are 0xC0 for register 0x00, 0xF7 for 0x10, 0x77 for 0x11 and 0x12, and 0xFF for 0x13 and for every other address.
- R10: Reset sets registers 0x10, 0x11, 0x12 and 0x13 to 0x44, 0x62, 0x01 and 0x00, and every other register to 0x00.
- R11: A write byte is stored when its eighth bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| sen_n | input | 1 | Active-low transaction select |
| sdio_in | input | 1 | Value received on the shared data line |
| sdio_out | output | 1 | Value driven onto the shared data line |
| sdio_oe | output | 1 | Output-enable of the shared data line |
| sdo_out | output | 1 | Value driven onto the dedicated output line |
| sdo_oe | output | 1 | Output-enable of the dedicated output line |

## Verification
The assertions assume the serial clock, select and data change slowly compared with the system clock. Each serial level must last longer than the resynchronising stages plus one cycle, so that every edge is seen exactly once and the data bit is stable when its rising edge is detected. They also assume select is asserted a few system cycles before the first serial edge. The stimulus holds every serial half-period for eight system cycles and changes data only while the serial clock is low. It also waits a half-period after each change of select, so the checked behaviour never depends on edges closer than the sampler can resolve.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_DONE
  } xfer_st_t;

  // Bits each register actually implements; the rest are held at zero.
  function automatic logic [DATA_W-1:0] bit_mask(input logic [ADDR_W-1:0] a);
    case (a)
      5'h00:        return 8'hC0;
      5'h10:        return 8'hF7;
      5'h11, 5'h12: return 8'h77;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(input logic [ADDR_W-1:0] a);
    case (a)
      5'h10:   return 8'h44;
      5'h11:   return 8'h62;
      5'h12:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          cfg_lsb_first,
  output logic          cfg_four_wire
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reset_val(AW'(i));
    end else if (we) begin
      mem[waddr] <= wdata & bit_mask(waddr);
    end
  end

  assign rdata         = mem[raddr];
  assign cfg_lsb_first = mem[0][6];
  assign cfg_four_wire = mem[0][7];

  // R9: undefined bits never read back as 1
  p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~bit_mask(raddr)) == '0);

  // R10: first cycle out of reset shows the documented defaults
  p_reset_val_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == reset_val(raddr));

  // R11: a write strobe lands in the addressed register on the next edge
  p_commit_r11: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == ($past(wdata) & bit_mask($past(waddr))));

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW          = ADDR_W,
  parameter int unsigned DW          = DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic sen_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo_out,
  output logic sdo_oe
);

  localparam int unsigned BIT_W = $clog2(DW);
  localparam int unsigned CNT_W = 2;

  // ---------------- pin resampling and edge detect
  logic [2:0] pins_q;
  logic       sclk_q, sen_q, din_q, sclk_d1;
  logic       rise, fall;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, sen_n, sdio_in}),
    .q   (pins_q)
  );

  assign {sclk_q, sen_q, din_q} = pins_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_d1 <= 1'b0;
    else     sclk_d1 <= sclk_q;
  end

  assign rise = sclk_q & ~sclk_d1;
  assign fall = ~sclk_q & sclk_d1;

  // ---------------- byte sequencer
  xfer_st_t         st;
  logic [BIT_W-1:0] bit_cnt;
  logic [DW-1:0]    sh;
  logic             rd;
  logic [CNT_W-1:0] left;
  logic [AW-1:0]    addr;
  logic             lsb_l, fw_l;
  logic             cfg_lsb, cfg_fw;
  logic [DW-1:0]    rx_next, rdata;
  logic             byte_end, we;
  logic [AW-1:0]    addr_step;

  assign rx_next   = lsb_l ? {din_q, sh[DW-1:1]} : {sh[DW-2:0], din_q};
  assign byte_end  = rise && (bit_cnt == BIT_W'(DW-1));
  assign addr_step = lsb_l ? addr + 1'b1 : addr - 1'b1;
  assign we        = (st == ST_DATA) && !sen_q && !rd && byte_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      sh      <= '0;
      rd      <= 1'b0;
      left    <= '0;
      addr    <= '0;
      lsb_l   <= 1'b0;
      fw_l    <= 1'b0;
    end else if (sen_q) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          lsb_l   <= cfg_lsb;
          fw_l    <= cfg_fw;
          bit_cnt <= '0;
          st      <= ST_HDR;
        end
        ST_HDR: if (rise) begin
          sh      <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (byte_end) begin
            rd      <= rx_next[DW-1];
            left    <= rx_next[AW+CNT_W-1:AW];
            addr    <= rx_next[AW-1:0];
            bit_cnt <= '0;
            st      <= ST_DATA;
          end
        end
        ST_DATA: if (rise) begin
          sh      <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (byte_end) begin
            bit_cnt <= '0;
            addr    <= addr_step;
            if (left == '0) st   <= ST_DONE;
            else            left <= left - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  spi_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .we            (we),
    .waddr         (addr),
    .wdata         (rx_next),
    .raddr         (addr),
    .rdata         (rdata),
    .cfg_lsb_first (cfg_lsb),
    .cfg_four_wire (cfg_fw)
  );

  // ---------------- read shifter and output registers
  logic [BIT_W-1:0] tx_idx;
  logic             tx_bit;

  assign tx_idx = lsb_l ? bit_cnt : BIT_W'(DW-1) - bit_cnt;
  assign tx_bit = rdata[tx_idx];

  always_ff @(posedge clk) begin
    if (rst || sen_q) begin
      sdio_out <= 1'b0;
      sdo_out  <= 1'b0;
      sdio_oe  <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (fall) begin
      if (st == ST_DATA && rd) begin
        sdio_out <= tx_bit;
        sdo_out  <= tx_bit;
        sdio_oe  <= !fw_l;
        sdo_oe   <= fw_l;
      end else begin
        sdio_oe  <= 1'b0;
        sdo_oe   <= 1'b0;
      end
    end
  end

  // R5: never both lines driven
  p_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sdio_oe, sdo_oe}));

  // R3: deselect silences both lines
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (rst)
    sen_q |=> !sdio_oe && !sdo_oe);

  // R4: dedicated line stays off in 3-wire transactions
  p_no_sdo_3w_r4: assert property (@(posedge clk) disable iff (rst)
    !fw_l |-> !sdo_oe);

  // R6: a write transfer never drives either line
  p_no_drive_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && !rd) |-> !sdio_oe && !sdo_oe);

  // R8: address moves one step in the direction set by bit order
  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && !sen_q && byte_end && left != '0) |=>
      addr == ($past(lsb_l) ? AW'($past(addr) + 1'b1) : AW'($past(addr) - 1'b1)));

endmodule

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sen_n = 1'b1;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;

  always #2 clk = ~clk;

  spi_cfg_slave dut (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .sen_n    (sen_n),
    .sdio_in  (sdio_in),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .sdo_out  (sdo_out),
    .sdo_oe   (sdo_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model [32];
  logic       mdl_lsb = 1'b0;
  logic       mdl_fw  = 1'b0;
  logic [7:0] exp_q [$];
  bit         rd_phase = 1'b0;
  string      rd_tag = "R1";

  function automatic logic [7:0] tb_mask(input logic [4:0] a);
    if (a == 5'd0)                 return 8'b1100_0000;
    if (a == 5'd16)                return 8'b1111_0111;
    if (a == 5'd17 || a == 5'd18)  return 8'b0111_0111;
    return 8'b1111_1111;
  endfunction

  function automatic logic [7:0] tb_rst(input logic [4:0] a);
    if (a == 5'd16) return 8'd68;
    if (a == 5'd17) return 8'd98;
    if (a == 5'd18) return 8'd1;
    return 8'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdio_in = b;
    half();
    sclk = 1'b1;
    half();
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(mdl_lsb ? b[i] : b[7-i]);
  endtask

  // driver: performs one transaction and queues the bytes a read must return
  task automatic xfer(input bit rd, input int n, input logic [4:0] a, input logic [31:0] wd, input string tag);
    logic [4:0] cur;
    logic [7:0] hdr;
    hdr = {rd, 2'(n - 1), a};
    cur = a;
    rd_tag = tag;
    sen_n = 1'b0;
    half();
    send_byte(hdr);
    if (rd) rd_phase = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (rd) begin
        exp_q.push_back(model[cur]);
        for (int i = 0; i < 8; i++) send_bit(1'(i));
      end else begin
        send_byte(wd[8*k +: 8]);
        model[cur] = wd[8*k +: 8] & tb_mask(cur);
      end
      cur = mdl_lsb ? cur + 5'd1 : cur - 5'd1;
    end
    rd_phase = 1'b0;
    half();
    chk(!sdio_oe && !sdo_oe, "R6 lines released after last bit", {sdio_oe, sdo_oe}, 0);
    sen_n = 1'b1;
    half();
    chk(!sdio_oe && !sdo_oe, "R3 lines off while deselected", {sdio_oe, sdo_oe}, 0);
    mdl_lsb = model[0][6];
    mdl_fw  = model[0][7];
  endtask

  // monitor: samples at each rising serial edge and compares against the queue
  logic [7:0] acc;
  int         nbit = 0;
  always @(posedge sclk) begin
    if (rd_phase) begin
      chk(sdio_oe == !mdl_fw, "R4 shared line enable during read", sdio_oe, !mdl_fw);
      chk(sdo_oe == mdl_fw, "R5 dedicated line enable during read", sdo_oe, mdl_fw);
      if (mdl_lsb) acc[nbit] = mdl_fw ? sdo_out : sdio_out;
      else         acc[7-nbit] = mdl_fw ? sdo_out : sdio_out;
      nbit++;
      if (nbit == 8) begin
        nbit = 0;
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected read byte", acc, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(acc == e, rd_tag, acc, e);
        end
      end
    end else if (!sen_n) begin
      chk(!sdio_oe && !sdo_oe, "R6 no drive outside read data", {sdio_oe, sdo_oe}, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = tb_rst(5'(i));
    repeat (5) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R3 reset leaves lines off", {sdio_oe, sdo_oe}, 0);
    rst = 1'b0;
    half();

    // R10 defaults, MSB-first downward burst from the last address
    xfer(1'b1, 4, 5'h13, 0, "R10 reset value");
    xfer(1'b1, 1, 5'h00, 0, "R10 register 0 reset");
    // R1 R8 R11 write burst MSB first, read back
    xfer(1'b0, 3, 5'h0A, 32'h007E_3CA5, "R11");
    xfer(1'b1, 3, 5'h0A, 0, "R11 R8 MSB-first burst readback");
    // R9 undefined bits
    xfer(1'b0, 4, 5'h13, 32'hFFFF_FFFF, "R9");
    xfer(1'b1, 4, 5'h13, 0, "R9 masked readback");
    xfer(1'b0, 1, 5'h00, 32'h0000_003F, "R9");
    xfer(1'b1, 1, 5'h00, 0, "R9 register 0 masked");
    // R8 wrap downward: 0 then 31
    xfer(1'b0, 2, 5'h00, 32'h0000_5A00, "R8");
    xfer(1'b1, 2, 5'h00, 0, "R8 downward wrap readback");
    // R7 LSB first, upward wrap 30,31,0
    xfer(1'b0, 1, 5'h00, 32'h0000_0040, "R7");
    xfer(1'b0, 3, 5'h1E, 32'h0040_2211, "R7");
    xfer(1'b1, 3, 5'h1E, 0, "R7 R8 LSB-first upward wrap readback");
    xfer(1'b1, 2, 5'h08, 0, "R7 R2 LSB-first read");
    // R5 4-wire, LSB then MSB
    xfer(1'b0, 1, 5'h00, 32'h0000_00C0, "R5");
    xfer(1'b1, 4, 5'h08, 0, "R5 4-wire LSB read");
    xfer(1'b0, 1, 5'h00, 32'h0000_0080, "R5");
    xfer(1'b1, 2, 5'h11, 0, "R5 4-wire MSB read");
    // back to 3-wire MSB
    xfer(1'b0, 1, 5'h00, 32'h0000_0000, "R4");
    xfer(1'b1, 1, 5'h00, 0, "R4 register 0 cleared");

    // R3 abort mid-byte: header for write 0x0A, then 4 data bits only
    sen_n = 1'b0;
    half();
    send_byte(8'h0A);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    sen_n = 1'b1;
    half();
    chk(!sdio_oe && !sdo_oe, "R3 abort releases lines", {sdio_oe, sdo_oe}, 0);
    xfer(1'b1, 1, 5'h0A, 0, "R3 aborted byte not written");

    // R3 serial clocking while deselected has no effect
    for (int i = 0; i < 12; i++) begin
      sdio_in = 1'(i);
      half();
      sclk = 1'b1;
      half();
      chk(!sdio_oe && !sdo_oe, "R3 deselected clocking", {sdio_oe, sdo_oe}, 0);
      sclk = 1'b0;
    end
    xfer(1'b1, 4, 5'h13, 0, "R3 registers kept through deselected clocking");
    xfer(1'b1, 1, 5'h00, 0, "R3 register 0 kept");

    chk(exp_q.size() == 0, "R1 every read byte delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule